// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block holds one captured timestamp for receive traffic and one for transmit traffic. An upstream classifier raises a single-cycle event pulse for a packet that needs a timestamp. If timestamping is enabled for that direction and the latch is empty, the block stores the 64-bit value of the free-running time counter in that cycle. It then sets a valid flag and bumps a 16-bit capture count.

Once a timestamp is held, it stays put. Software first reads a status word and checks the valid flag. It then reads the low and high halves of the stored time. Finally it re-arms the latch by writing the status word with the valid bit set. Each direction has its own enable register. When timestamping is turned on, software normally re-arms the latch as well, so that no stale value survives.

Register access uses a simple word-addressed port. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `ts_capture_pair`

## Requirements
- R1: After reset, every register of both directions reads zero: status, low time, high time and enable.
- R2: A status read (offset 0) returns the valid flag at bit 16 and the capture count at bits 15:0, with all other bits zero. The count rises by exactly one on each accepted capture.
- R3: An event pulse in a cycle where the direction is enabled and its latch is empty stores `time_now` from that clock edge. From the next cycle the valid bit is set, offset 1 reads time bits 31:0 and offset 2 reads time bits 63:32.
- R4: While the valid flag is set and no re-arm write arrives, event pulses are ignored. The stored time and the count do not change.
- R5: A write to the status offset with bit 16 set clears the valid flag and leaves the stored time readable. A status write with bit 16 clear has no effect.
- R6: If a re-arm write and an enabled event fall in the same cycle, the re-arm applies first and the event is captured. The valid flag stays set, the count rises and the new time is stored.
- R7: While the enable bit of a direction is 0, its event pulses never set the valid flag or change the stored data.
- R8: Offset 3 is the enable register. Bit 0 of a write sets the enable, and a read returns the enable in bit 0 with all other bits zero.
- R9: Address bit 2 selects the direction (0 receive, 1 transmit). The two latches are independent, so activity on one never changes what the other reads.
- R10: Writes to the low and high time offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_evt | input | 1 | Receive timestamp event pulse |
| tx_evt | input | 1 | Transmit timestamp event pulse |
| time_now | input | 64 | Current time from the time counter |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address: bit 2 direction, bits 1:0 register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |

## Verification
The properties assume that the event inputs and the write port are steady around each rising edge. They also assume that `time_now` is a plain input whose value at the capture edge is the one to be stored. No ordering is assumed between events and re-arm writes, so the collision case is covered like any other cycle.

The stimulus changes every input only a couple of nanoseconds after an edge. A directed phase reaches each corner on purpose:
- a capture while disabled,
- an event against a full latch,
- a status write with bit 16 clear,
- a same-cycle re-arm and event.

A random phase then mixes events on both directions with writes to every offset, while a behavioural model is compared against whatever address is presented each cycle.

// File: rtl/ts_capture_pair.sv
module ts_capture_pair #(
  parameter int TIME_W  = 64,
  parameter int DATA_W  = 32,
  parameter int SEQ_W   = 16,
  parameter int VLD_BIT = 16,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_evt,
  input  logic              tx_evt,
  input  logic [TIME_W-1:0] time_now,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int NDIR = 2;
  localparam logic [1:0] OFS_STAT = 2'd0;
  localparam logic [1:0] OFS_LO   = 2'd1;
  localparam logic [1:0] OFS_HI   = 2'd2;
  localparam logic [1:0] OFS_EN   = 2'd3;

  logic [NDIR-1:0] evt;
  logic [NDIR-1:0] en_q, vld_q;
  logic [NDIR-1:0][SEQ_W-1:0] seq_q;
  logic [NDIR-1:0][TIME_W-1:0] stamp_q;

  assign evt = {tx_evt, rx_evt};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic hit, wr_en, wr_clr, take;
    logic en_r, vld_r;
    logic [SEQ_W-1:0] seq_r;
    logic [TIME_W-1:0] stamp_r;

    assign hit    = bus_wr && (bus_addr[2] == 1'(d));
    assign wr_en  = hit && (bus_addr[1:0] == OFS_EN);
    assign wr_clr = hit && (bus_addr[1:0] == OFS_STAT) && bus_wdata[VLD_BIT];
    assign take   = evt[d] && en_r && (!vld_r || wr_clr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_r    <= 1'b0;
        vld_r   <= 1'b0;
        seq_r   <= '0;
        stamp_r <= '0;
      end else begin
        if (wr_en) en_r <= bus_wdata[0];
        if (take) begin
          vld_r   <= 1'b1;
          stamp_r <= time_now;
          seq_r   <= seq_r + 1'b1;
        end else if (wr_clr) begin
          vld_r <= 1'b0;
        end
      end
    end

    assign en_q[d]    = en_r;
    assign vld_q[d]   = vld_r;
    assign seq_q[d]   = seq_r;
    assign stamp_q[d] = stamp_r;
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr[1:0])
      OFS_STAT: begin
        bus_rdata[SEQ_W-1:0] = seq_q[bus_addr[2]];
        bus_rdata[VLD_BIT]   = vld_q[bus_addr[2]];
      end
      OFS_LO:  bus_rdata = stamp_q[bus_addr[2]][DATA_W-1:0];
      OFS_HI:  bus_rdata = stamp_q[bus_addr[2]][2*DATA_W-1:DATA_W];
      default: bus_rdata[0] = en_q[bus_addr[2]];
    endcase
  end
endmodule

module ts_capture_chk #(
  parameter int TIME_W  = 64,
  parameter int DATA_W  = 32,
  parameter int SEQ_W   = 16,
  parameter int VLD_BIT = 16,
  parameter int ADDR_W  = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rx_evt,
  input logic                        tx_evt,
  input logic [TIME_W-1:0]           time_now,
  input logic                        bus_wr,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic [1:0]                  en_q,
  input logic [1:0]                  vld_q,
  input logic [1:0][SEQ_W-1:0]       seq_q,
  input logic [1:0][TIME_W-1:0]      stamp_q
);
  logic unused_chk;
  assign unused_chk = ^bus_wdata;

  for (genvar d = 0; d < 2; d++) begin : g_chk
    logic ev, clr;
    assign ev  = (d == 0) ? rx_evt : tx_evt;
    assign clr = bus_wr && (bus_addr == {1'(d), 2'd0}) && bus_wdata[VLD_BIT];

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && en_q[d] && !vld_q[d]) |=> (vld_q[d] && stamp_q[d] == $past(time_now)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[d] && !clr) |=> (vld_q[d] && $stable(stamp_q[d]) && $stable(seq_q[d])));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(ev && en_q[d])) |=> !vld_q[d]);

    p_race_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && ev && en_q[d]) |=> (vld_q[d] && stamp_q[d] == $past(time_now)));

    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[d] |=> (!$rose(vld_q[d]) && $stable(stamp_q[d])));

    p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(seq_q[d]) |-> (seq_q[d] == SEQ_W'($past(seq_q[d]) + 1'b1)));
  end
endmodule

bind ts_capture_pair ts_capture_chk #(
  .TIME_W(TIME_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W), .VLD_BIT(VLD_BIT), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt), .time_now(time_now),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .en_q(en_q), .vld_q(vld_q), .seq_q(seq_q), .stamp_q(stamp_q)
);

// File: tb/tb_ts_capture_pair.sv
`timescale 1ns/1ps
module tb_ts_capture_pair;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rx_evt = 0, tx_evt = 0;
  logic [63:0] time_now = 64'hA5A5_0001_0000_0000;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;

  int n_chk = 0, n_fail = 0;

  bit          m_en[2], m_vld[2];
  logic [15:0] m_seq[2];
  logic [63:0] m_stamp[2];

  always #4 clk = ~clk;

  ts_capture_pair dut (
    .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt), .time_now(time_now),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [2:0] a);
    int d = int'(a[2]);
    case (a[1:0])
      2'd0:    return {15'b0, m_vld[d], m_seq[d]};
      2'd1:    return m_stamp[d][31:0];
      2'd2:    return m_stamp[d][63:32];
      default: return {31'b0, m_en[d]};
    endcase
  endfunction

  task automatic model_edge();
    bit ev[2];
    ev[0] = rx_evt;
    ev[1] = tx_evt;
    for (int d = 0; d < 2; d++) begin
      bit sel = bus_wr && (int'(bus_addr[2]) == d);
      bit clr = sel && bus_addr[1:0] == 2'd0 && bus_wdata[16];
      bit take = ev[d] && m_en[d] && (!m_vld[d] || clr);
      if (take) begin
        m_vld[d] = 1;
        m_stamp[d] = time_now;
        m_seq[d] = m_seq[d] + 16'd1;
      end else if (clr) m_vld[d] = 0;
      if (sel && bus_addr[1:0] == 2'd3) m_en[d] = bus_wdata[0];
    end
  endtask

  task automatic tick();
    string tag;
    @(posedge clk);
    model_edge();
    #2;
    case (bus_addr[1:0])
      2'd0: tag = "R2 status";
      2'd3: tag = "R8 enable";
      default: tag = "R3 time";
    endcase
    chk($sformatf("%s cycle compare addr=%0d", tag, bus_addr), bus_rdata, exp_read(bus_addr));
    time_now = time_now + 64'h0000_0001_0000_0003;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    bus_wr = 0;
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] v);
    bus_wr = 1; bus_addr = a; bus_wdata = v;
    tick();
    bus_wr = 0;
  endtask

  task automatic pulse(int d, output logic [63:0] t);
    t = time_now;
    if (d == 0) rx_evt = 1; else tx_evt = 1;
    tick();
    rx_evt = 0; tx_evt = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] t1, t2, t3, t4;
    for (int d = 0; d < 2; d++) begin
      m_en[d] = 0; m_vld[d] = 0; m_seq[d] = 0; m_stamp[d] = 0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1 reset value");

    pulse(0, t1);
    rd(3'd0, 32'h0, "R7 disabled event ignored");

    wr(3'd3, 32'h0000_0001);
    rd(3'd3, 32'h1, "R8 enable readback");

    pulse(0, t1);
    rd(3'd0, 32'h0001_0001, "R2 status after capture");
    rd(3'd1, t1[31:0], "R3 low half");
    rd(3'd2, t1[63:32], "R3 high half");

    pulse(0, t2);
    rd(3'd1, t1[31:0], "R4 held low half");
    rd(3'd2, t1[63:32], "R4 held high half");
    rd(3'd0, 32'h0001_0001, "R4 status held");

    wr(3'd0, 32'h0000_FFFF);
    rd(3'd0, 32'h0001_0001, "R5 write without bit16 ignored");
    wr(3'd0, 32'h0001_0000);
    rd(3'd0, 32'h0000_0001, "R5 re-arm clears valid");
    rd(3'd1, t1[31:0], "R5 data kept after re-arm");

    pulse(0, t2);
    rd(3'd0, 32'h0001_0002, "R2 second capture count");
    bus_wr = 1; bus_addr = 3'd0; bus_wdata = 32'h0001_0000; rx_evt = 1; t3 = time_now;
    tick();
    bus_wr = 0; rx_evt = 0;
    rd(3'd0, 32'h0001_0003, "R6 same-cycle re-arm and event");
    rd(3'd1, t3[31:0], "R6 new low half");
    rd(3'd2, t3[63:32], "R6 new high half");

    rd(3'd4, 32'h0, "R9 tx untouched by rx");
    wr(3'd7, 32'h0000_0001);
    pulse(1, t4);
    rd(3'd4, 32'h0001_0001, "R9 tx status");
    rd(3'd5, t4[31:0], "R9 tx low half");
    rd(3'd6, t4[63:32], "R9 tx high half");
    rd(3'd0, 32'h0001_0003, "R9 rx status unchanged");
    rd(3'd1, t3[31:0], "R9 rx data unchanged");

    wr(3'd1, 32'hDEAD_BEEF);
    rd(3'd1, t3[31:0], "R10 low half write ignored");
    wr(3'd2, 32'hCAFE_F00D);
    rd(3'd2, t3[63:32], "R10 high half write ignored");

    wr(3'd3, 32'h0);
    wr(3'd0, 32'h0001_0000);
    pulse(0, t1);
    rd(3'd0, 32'h0000_0003, "R7 disabled after re-arm");
    rd(3'd3, 32'h0, "R8 enable cleared");
    rd(3'd1, t3[31:0], "R7 data unchanged");

    for (int i = 0; i < 600; i++) begin
      rx_evt = ($urandom_range(0, 1) == 1);
      tx_evt = ($urandom_range(0, 2) == 0);
      bus_wr = ($urandom_range(0, 3) == 0);
      bus_addr = 3'($urandom_range(0, 7));
      bus_wdata = $urandom;
      if (bus_wr && bus_addr[1:0] == 2'd3) bus_wdata[0] = ($urandom_range(0, 3) != 0);
      tick();
    end
    rx_evt = 0; tx_evt = 0; bus_wr = 0;
    for (int a = 0; a < 8; a++) rd(3'(a), exp_read(3'(a)), "R9 final state per direction");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule